// File: doc/BRIEF.md
# Physical Register Free List

This block keeps the pool of unused physical register indices for a rename stage that handles several instructions per cycle. The pool is a circular array read at a head pointer and written at a tail pointer. Each rename slot raises its own request bit. The block then offers one distinct free index to every requesting slot. Requesting slots take consecutive entries from the head in slot order. Slots that do not request consume nothing.

A single `can_alloc` flag reports whether the whole group of requests can be served. The head only moves when the caller also raises `alloc_commit` in that cycle. `can_alloc` therefore acts as the ready side of the allocation handshake: the caller holds its requests and its indices stay on offer until it commits in a cycle where `can_alloc` is high. No index is ever handed out to part of a group.

Retiring instructions return the previous mapping of their destination through per-slot release ports. Released indices are appended at the tail. Two recovery paths exist:
- A walk rolls the head back by a count of squashed allocations.
- A flush makes every in-flight index free again at once.

A redirect blocks allocation for its cycle.

Top module: `phys_free_list`

## Requirements
- R1: After reset the list holds the indices NARCH to NPHYS-1 in ascending order. The first group served receives NARCH, NARCH+1, and so on, and `can_alloc` is 1.
- R2: Slot j is offered the entry at head plus the number of requesting slots below j. Non-requesting slots do not shift the numbering, and on commit the head advances by the number of requests.
- R3: `can_alloc` is 1 exactly when the free count is at least the number of set request bits and no walk, redirect or flush is active. Zero requests with an empty list still give 1.
- R4: The head moves forward only in a cycle with both `alloc_commit` and `can_alloc` high. Otherwise the same indices are offered again in the next cycle.
- R5: While `walk_valid` is high, `can_alloc` is 0 and the head moves back by `walk_cnt` in the next cycle. The walked indices are offered again, oldest first.
- R6: `redirect` forces `can_alloc` to 0 for its cycle and leaves the pointers unchanged.
- R7: Each release slot with its valid bit set appends its index at the tail. Several releases in one cycle are appended in release-slot order, ahead of any later release.
- R8: `flush` forces `can_alloc` to 0. In the next cycle the free count equals the list depth, and the oldest in-flight index is offered first. Flush has priority over walk, and walk has priority over allocation.
- R9: The free count never exceeds the depth NPHYS-NARCH, and after a flush exactly that many indices can be allocated before `can_alloc` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | W | Per-slot allocation request |
| alloc_commit | input | 1 | Take the offered indices this cycle |
| can_alloc | output | 1 | Whole request group can be served |
| alloc_idx | output | W*log2(NPHYS) | Offered index per slot, slot 0 in the low bits |
| walk_valid | input | 1 | Rollback walk active |
| walk_cnt | input | log2(CW+1) | Number of allocations to give back |
| redirect | input | 1 | Mispredict recovery in progress; blocks allocation |
| flush | input | 1 | Return every in-flight index |
| dealloc_valid | input | CW | Per-slot release valid |
| dealloc_idx | input | CW*log2(NPHYS) | Released index per slot, slot 0 in the low bits |

## Verification
The bench attacks sparse request patterns. A design that numbered offers by slot position instead of by rank would hand slot 3 an index beyond the next free one. It drains the list to an exact fit and then to one short, where a partial grant or an off-by-one compare in the free count would show. Walks are checked by the order in which squashed indices come back; a design that moved the head the wrong way, or by the wrong amount, would offer fresh indices instead. Releases on non-adjacent slots, and a flush after a mix of allocations and retirements, expose any tail packing error or a wrong full-list head, and a full drain after the flush catches any capacity miscount.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD  = 2'd0,
    PTR_ALLOC = 2'd1,
    PTR_WALK  = 2'd2,
    PTR_FLUSH = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/fl_rank.sv
module fl_rank #(
  parameter int N  = 4,
  parameter int RW = $clog2(N + 1)
) (
  input  logic [N-1:0]    bits_in,
  output logic [N*RW-1:0] rank,
  output logic [RW-1:0]   total
);
  logic [RW-1:0] acc;

  // rank of slot i = number of set bits strictly below i
  always_comb begin
    acc  = '0;
    rank = '0;
    for (int i = 0; i < N; i++) begin
      rank[i*RW +: RW] = acc;
      acc = acc + RW'(bits_in[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/fl_ptr.sv
module fl_ptr #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int RW    = 3,
  parameter int DRW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fl_pkg::ptr_op_e  op,
  input  logic [RW-1:0]    alloc_n,
  input  logic [DRW-1:0]   walk_n,
  input  logic [DRW-1:0]   dealloc_n,
  output logic [AW:0]      head,
  output logic [AW:0]      tail,
  output logic [AW:0]      free_cnt
);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [AW:0] head_nx, tail_nx;

  assign tail_nx  = tail + (AW+1)'(dealloc_n);
  assign free_cnt = tail - head;

  always_comb begin
    case (op)
      fl_pkg::PTR_ALLOC: head_nx = head + (AW+1)'(alloc_n);
      fl_pkg::PTR_WALK:  head_nx = head - (AW+1)'(walk_n);
      fl_pkg::PTR_FLUSH: head_nx = tail_nx - FULL;
      default:           head_nx = head;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= FULL;
    end else begin
      head <= head_nx;
      tail <= tail_nx;
    end
  end

  // R9: occupancy stays inside the array
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= FULL);
endmodule

// File: rtl/fl_store.sv
module fl_store #(
  parameter int W     = 4,
  parameter int CW    = 4,
  parameter int DEPTH = 32,
  parameter int NARCH = 32,
  parameter int PW    = 6,
  parameter int AW    = $clog2(DEPTH),
  parameter int RW    = $clog2(W + 1),
  parameter int DRW   = $clog2(CW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     head_lo,
  input  logic [AW-1:0]     tail_lo,
  input  logic [W*RW-1:0]   rd_rank,
  input  logic [CW-1:0]     wr_valid,
  input  logic [CW*DRW-1:0] wr_rank,
  input  logic [CW*PW-1:0]  wr_idx,
  output logic [W*PW-1:0]   rd_idx
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= PW'(NARCH + k);
    end else begin
      for (int c = 0; c < CW; c++) begin
        if (wr_valid[c])
          mem[tail_lo + AW'(wr_rank[c*DRW +: DRW])] <= wr_idx[c*PW +: PW];
      end
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_rd
    assign rd_idx[i*PW +: PW] = mem[head_lo + AW'(rd_rank[i*RW +: RW])];
  end
endmodule

// File: rtl/phys_free_list.sv
module phys_free_list #(
  parameter int W     = 4,
  parameter int CW    = 4,
  parameter int NPHYS = 64,
  parameter int NARCH = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [W-1:0]                alloc_req,
  input  logic                        alloc_commit,
  output logic                        can_alloc,
  output logic [W*$clog2(NPHYS)-1:0]  alloc_idx,
  input  logic                        walk_valid,
  input  logic [$clog2(CW+1)-1:0]     walk_cnt,
  input  logic                        redirect,
  input  logic                        flush,
  input  logic [CW-1:0]               dealloc_valid,
  input  logic [CW*$clog2(NPHYS)-1:0] dealloc_idx
);
  localparam int DEPTH = NPHYS - NARCH;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(NPHYS);
  localparam int RW    = $clog2(W + 1);
  localparam int DRW   = $clog2(CW + 1);

  logic [W*RW-1:0]   a_rank;
  logic [RW-1:0]     a_total;
  logic [CW*DRW-1:0] d_rank;
  logic [DRW-1:0]    d_total;
  logic [AW:0]       head, tail, free_cnt;
  fl_pkg::ptr_op_e   op;

  fl_rank #(.N(W), .RW(RW)) u_arank (
    .bits_in(alloc_req), .rank(a_rank), .total(a_total));

  fl_rank #(.N(CW), .RW(DRW)) u_drank (
    .bits_in(dealloc_valid), .rank(d_rank), .total(d_total));

  assign can_alloc = !flush && !walk_valid && !redirect &&
                     (free_cnt >= (AW+1)'(a_total));

  always_comb begin
    if (flush)                          op = fl_pkg::PTR_FLUSH;
    else if (walk_valid)                op = fl_pkg::PTR_WALK;
    else if (can_alloc && alloc_commit) op = fl_pkg::PTR_ALLOC;
    else                                op = fl_pkg::PTR_HOLD;
  end

  fl_ptr #(.DEPTH(DEPTH), .AW(AW), .RW(RW), .DRW(DRW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .op(op), .alloc_n(a_total),
    .walk_n(walk_cnt), .dealloc_n(d_total),
    .head(head), .tail(tail), .free_cnt(free_cnt));

  fl_store #(.W(W), .CW(CW), .DEPTH(DEPTH), .NARCH(NARCH), .PW(PW),
             .AW(AW), .RW(RW), .DRW(DRW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .head_lo(head[AW-1:0]), .tail_lo(tail[AW-1:0]),
    .rd_rank(a_rank), .wr_valid(dealloc_valid), .wr_rank(d_rank),
    .wr_idx(dealloc_idx), .rd_idx(alloc_idx));

  // R4: no commit, no move (absent walk/flush)
  assert_head_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(alloc_commit && can_alloc) && !walk_valid && !flush) |=> $stable(head));
  // R5: walk rolls the head back by the count
  assert_walk_rewinds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && !flush) |=> head == $past(head) - (AW+1)'($past(walk_cnt)));
  // R5 / R6: recovery cycles grant nothing
  assert_recovery_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid || redirect) |-> !can_alloc);
  // R8: flush refills the whole list
  assert_flush_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> free_cnt == (AW+1)'(DEPTH));
endmodule

// File: tb/phys_free_list_tb.sv
module phys_free_list_tb;
  localparam int W = 4, CW = 4, NPHYS = 64, NARCH = 32, PW = 6;

  logic clk = 0, rst_n = 0;
  logic [W-1:0]    alloc_req = '0;
  logic            alloc_commit = 0;
  logic            can_alloc;
  logic [W*PW-1:0] alloc_idx;
  logic            walk_valid = 0;
  logic [2:0]      walk_cnt = '0;
  logic            redirect = 0, flush = 0;
  logic [CW-1:0]   dealloc_valid = '0;
  logic [CW*PW-1:0] dealloc_idx = '0;

  always #2.5 clk = ~clk;

  phys_free_list #(.W(W), .CW(CW), .NPHYS(NPHYS), .NARCH(NARCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_commit(alloc_commit),
    .can_alloc(can_alloc), .alloc_idx(alloc_idx), .walk_valid(walk_valid),
    .walk_cnt(walk_cnt), .redirect(redirect), .flush(flush),
    .dealloc_valid(dealloc_valid), .dealloc_idx(dealloc_idx));

  typedef struct { string tag; int slot; int val; } exp_t;
  exp_t exp_q[$];
  int fl[$], inflight[$], arch_pool[$];
  int checks = 0, errors = 0;
  bit done = 0;
  event sample_ev;

  // monitor: pops expectations and compares with the ports
  initial forever begin
    @(sample_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      int act;
      e = exp_q.pop_front();
      act = (e.slot < 0) ? int'(can_alloc) : int'(alloc_idx[e.slot*PW +: PW]);
      checks++;
      if (act != e.val) begin
        errors++;
        $display("FAIL %s slot %0d: actual %0d expected %0d", e.tag, e.slot, act, e.val);
      end
    end
  end

  task automatic cyc(input string tag, input logic [W-1:0] req, input logic cm,
                     input logic wv, input int wc, input logic rd, input logic fls,
                     input logic [CW-1:0] dv);
    int dq[$];
    int n, k;
    bit exp_can;
    @(negedge clk);
    alloc_req = req; alloc_commit = cm; walk_valid = wv; walk_cnt = 3'(wc);
    redirect = rd; flush = fls; dealloc_valid = dv; dealloc_idx = '0;
    for (int c = 0; c < CW; c++) begin
      if (dv[c]) begin
        int v;
        v = arch_pool.pop_front();
        dealloc_idx[c*PW +: PW] = PW'(v);
        arch_pool.push_back(inflight.pop_front());
        dq.push_back(v);
      end
    end
    #1;
    n = $countones(req);
    exp_can = !fls && !wv && !rd && (fl.size() >= n);
    exp_q.push_back('{tag, -1, int'(exp_can)});
    k = 0;
    for (int j = 0; j < W; j++) begin
      if (req[j]) begin
        if (k < fl.size()) exp_q.push_back('{tag, j, fl[k]});
        k++;
      end
    end
    ->sample_ev;
    wait (exp_q.size() == 0);
    if (fls) begin
      fl = {inflight, fl};
      inflight.delete();
    end else if (wv) begin
      for (int t = 0; t < wc; t++) fl.push_front(inflight.pop_back());
    end else if (exp_can && cm) begin
      for (int t = 0; t < n; t++) inflight.push_back(fl.pop_front());
    end
    foreach (dq[i]) fl.push_back(dq[i]);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPHYS - NARCH; i++) fl.push_back(NARCH + i);
    for (int i = 0; i < NARCH; i++) arch_pool.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R1 reset idle",   4'b0000, 0, 0, 0, 0, 0, 4'b0000);
    cyc("R1 first group",  4'b1111, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R2 sparse",       4'b1010, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R4 no commit",    4'b1111, 0, 0, 0, 0, 0, 4'b0000);
    cyc("R4 re-offer",     4'b0110, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R5 walk",         4'b1111, 1, 1, 3, 0, 0, 4'b0000);
    cyc("R5 after walk",   4'b0111, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R6 redirect",     4'b1111, 1, 0, 0, 1, 0, 4'b0000);
    cyc("R6 after",        4'b0001, 1, 0, 0, 0, 0, 4'b0000);
    for (int i = 0; i < 5; i++)
      cyc("R3 drain",      4'b1111, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R3 one short",    4'b1111, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R3 exact fit",    4'b0111, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R3 empty idle",   4'b0000, 0, 0, 0, 0, 0, 4'b0000);
    cyc("R3 empty one",    4'b0001, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R7 release",      4'b0000, 0, 0, 0, 0, 0, 4'b1101);
    cyc("R7 too few",      4'b1111, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R7 reuse order",  4'b0111, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R8 flush",        4'b1111, 1, 0, 0, 0, 1, 4'b0000);
    cyc("R8 after flush",  4'b1111, 1, 0, 0, 0, 0, 4'b0000);
    for (int i = 0; i < 7; i++)
      cyc("R9 refill drain", 4'b1111, 1, 0, 0, 0, 0, 4'b0000);
    cyc("R9 capacity end", 4'b0001, 1, 0, 0, 0, 0, 4'b0000);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule